// File: doc/BRIEF.md
# Bus Error Status Register

This block is the 16-bit status word of a bus device's configuration header. The bus interface logic raises single-cycle pulses when it sees a bus error condition. The register turns each pulse into a sticky flag that stays set until software clears it. Software reads the word through a read port that has no side effects. It clears flags through a write port that has per-byte enables. A one in the write data clears the matching flag. A zero leaves the flag alone. No write can ever set a flag.

Five flags are kept:

- **Detected parity error**, bit 15.
- **Signalled system error**, bit 14.
- **Received master abort**, bit 13.
- **Received target abort**, bit 12.
- **Master data parity reported**, bit 8.

The other fields are hardwired:

- Bit 4 shows that a capabilities list is present.
- Bits 10:9 carry the device-select timing code, fixed by a parameter.
- Every other bit is reserved and reads zero.

When an event pulse and a clearing write hit the same flag in the same cycle, the event wins, so no error is ever lost.

Top module: `bus_err_status`

## Requirements
- R1: After reset, and again after any later reset, `rd_data` equals 0x0010 with the `DEVSEL_TIMING` code placed in bits 10:9. With code 2'b10 the value is 0x0410.
- R2: Bits 3:0, 7:5 and 11 always read zero, and writes to these bits have no effect.
- R3: Bit 4 always reads one and bits 10:9 always read `DEVSEL_TIMING`, whatever is written.
- R4: A pulse on `ev_par_det` sets bit 15, whatever the level of `perr_resp_en`.
- R5: A pulse on `ev_serr` sets bit 14.
- R6: A pulse on `ev_mabort` sets bit 13, unless `ev_special` is high in the same cycle, in which case bit 13 is left unchanged.
- R7: A pulse on `ev_tabort` sets bit 12.
- R8: A pulse on `ev_mst_par` sets bit 8 only when `perr_resp_en` is high in the same cycle.
- R9: A write (`wr_en` high) clears every flag whose `wr_data` bit is one. Flags written with zero keep their value, and no write ever sets a bit.
- R10: `wr_be[0]` enables clearing in bits 7:0 and `wr_be[1]` enables clearing in bits 15:8. A flag in a disabled lane is not cleared.
- R11: An event and a clearing write to the same flag in the same cycle leave the flag set.
- R12: The flags are sticky. With no event and no clearing write, `rd_data` holds its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_par_det | input | 1 | Data parity error detected (pulse) |
| ev_serr | input | 1 | Device drove the system error signal (pulse) |
| ev_mabort | input | 1 | Own master transaction ended in master abort (pulse) |
| ev_special | input | 1 | Qualifies `ev_mabort`: the transaction was a special cycle |
| ev_tabort | input | 1 | Own master transaction ended in target abort (pulse) |
| ev_mst_par | input | 1 | Parity error seen as master (pulse) |
| perr_resp_en | input | 1 | Parity error response enable from the command register |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte-lane enables for the write |
| wr_data | input | 16 | Write data; a one clears the matching flag |
| rd_data | output | 16 | Current register contents |

## Verification
The hardest situation to reach is the collision between an event pulse and a clearing write in the same clock. The bench has to hold the pulse and the strobe together for exactly one edge.

The vector table schedules two such collisions:

- Detected parity error against a write of 0x8000.
- Master parity report against a write of 0x0100.

Each collision is placed right after the flag has been cleared, so a design that lets the clear win shows up as a zero at once.

The gated cases are placed the same way: a master abort qualified as a special cycle, and a master parity error with response disabled. Each is applied while its flag is known to be zero, so a wrong set is visible in the next read.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    localparam int unsigned REG_W     = 16;
    localparam int unsigned LANE_W    = 8;
    localparam int unsigned LANES     = REG_W / LANE_W;
    localparam int unsigned NUM_FLAGS = 5;

    // flag index -> bit position in the status word
    localparam int unsigned FLAG_DPE = 0;
    localparam int unsigned FLAG_SSE = 1;
    localparam int unsigned FLAG_RMA = 2;
    localparam int unsigned FLAG_RTA = 3;
    localparam int unsigned FLAG_DPR = 4;

    localparam int unsigned FLAG_POS [NUM_FLAGS] = '{15, 14, 13, 12, 8};

    localparam int unsigned CAP_BIT    = 4;
    localparam int unsigned DEVSEL_LSB = 9;

    function automatic logic [REG_W-1:0] flag_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            m[FLAG_POS[i]] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/bsr_clear_mask.sv
module bsr_clear_mask #(
    parameter int unsigned W      = 16,
    parameter int unsigned LANE_W = 8,
    localparam int unsigned LANES = W / LANE_W
) (
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_be,
    input  logic [W-1:0]     wr_data,
    output logic [W-1:0]     clr_mask
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign clr_mask[l*LANE_W +: LANE_W] =
            (wr_en && wr_be[l]) ? wr_data[l*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/bsr_sticky_bit.sv
module bsr_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // set has priority over clear so that an event is never dropped
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end
    end

endmodule

// File: rtl/bus_err_status.sv
module bus_err_status
    import bsr_pkg::*;
#(
    parameter logic [1:0] DEVSEL_TIMING = 2'b00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_par_det,
    input  logic             ev_serr,
    input  logic             ev_mabort,
    input  logic             ev_special,
    input  logic             ev_tabort,
    input  logic             ev_mst_par,
    input  logic             perr_resp_en,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_be,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data
);

    localparam logic [REG_W-1:0] FLAG_MASK = flag_mask();

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [REG_W-1:0]     clr_mask;
    logic                 unused_clr_bits;

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_DPE] = ev_par_det;
        set_vec[FLAG_SSE] = ev_serr;
        set_vec[FLAG_RMA] = ev_mabort & ~ev_special;
        set_vec[FLAG_RTA] = ev_tabort;
        set_vec[FLAG_DPR] = ev_mst_par & perr_resp_en;
    end

    bsr_clear_mask #(
        .W      (REG_W),
        .LANE_W (LANE_W)
    ) u_clr (
        .wr_en    (wr_en),
        .wr_be    (wr_be),
        .wr_data  (wr_data),
        .clr_mask (clr_mask)
    );

    // clear bits of hardwired positions are dropped here
    assign unused_clr_bits = ^(clr_mask & ~FLAG_MASK);

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        bsr_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[g]),
            .clr_i (clr_mask[FLAG_POS[g]]),
            .q_o   (flag_q[g])
        );
    end

    always_comb begin
        rd_data                       = '0;
        rd_data[CAP_BIT]              = 1'b1;
        rd_data[DEVSEL_LSB +: 2]      = DEVSEL_TIMING;
        for (int i = 0; i < NUM_FLAGS; i++) begin
            rd_data[FLAG_POS[i]] = flag_q[i];
        end
    end

endmodule

// File: rtl/bsr_chk.sv
module bsr_chk #(
    parameter logic [1:0] DEVSEL_TIMING = 2'b00
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ev_par_det,
    input logic        ev_serr,
    input logic        ev_mabort,
    input logic        ev_special,
    input logic        ev_tabort,
    input logic        ev_mst_par,
    input logic        perr_resp_en,
    input logic        wr_en,
    input logic [1:0]  wr_be,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data
);

    logic any_ev;
    assign any_ev = ev_par_det | ev_serr | ev_mabort | ev_tabort | ev_mst_par;

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3:0] == 4'h0) && (rd_data[7:5] == 3'h0) && !rd_data[11]);

    // R3
    fixed_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] && (rd_data[10:9] == DEVSEL_TIMING));

    // R4
    par_det_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_par_det |=> rd_data[15]);

    // R6
    special_mabort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mabort && ev_special && !rd_data[13]) |=> !rd_data[13]);

    // R8
    dpr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mst_par && !perr_resp_en && !rd_data[8]) |=> !rd_data[8]);

    // R9
    no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> ((rd_data & ~$past(rd_data)) == 16'h0000));

    // R10
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[15] && !(wr_en && wr_be[1] && wr_data[15])) |=> rd_data[15]);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tabort && wr_en && wr_be[1] && wr_data[12]) |=> rd_data[12]);

    // R12
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_ev && !wr_en) |=> $stable(rd_data));

endmodule

bind bus_err_status bsr_chk #(.DEVSEL_TIMING(DEVSEL_TIMING)) u_chk (.*);

// File: tb/tb_bus_err_status.sv
module tb_bus_err_status;

    localparam logic [1:0] DEVSEL = 2'b10;
    localparam int NVEC = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_par_det = 0, ev_serr = 0, ev_mabort = 0, ev_special = 0;
    logic        ev_tabort = 0, ev_mst_par = 0, perr_resp_en = 0, wr_en = 0;
    logic [1:0]  wr_be = 2'b00;
    logic [15:0] wr_data = 16'h0000;
    logic [15:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bus_err_status #(.DEVSEL_TIMING(DEVSEL)) dut (.*);

    // {ev: pdet,serr,mab,spec,tab,mpar}[41:36] pen[35] we[34] be[33:32] wd[31:16] exp[15:0]
    localparam logic [41:0] VEC [NVEC] = '{
        {6'b000000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h0410}, // R1
        {6'b100000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h8410}, // R4 pen low
        {6'b010000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'hC410}, // R5
        {6'b001100, 1'b0, 1'b0, 2'b00, 16'h0000, 16'hC410}, // R6 special
        {6'b001000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'hE410}, // R6
        {6'b000010, 1'b0, 1'b0, 2'b00, 16'h0000, 16'hF410}, // R7
        {6'b000001, 1'b0, 1'b0, 2'b00, 16'h0000, 16'hF410}, // R8 gated
        {6'b000001, 1'b1, 1'b0, 2'b00, 16'h0000, 16'hF510}, // R8
        {6'b000000, 1'b0, 1'b1, 2'b11, 16'h0000, 16'hF510}, // R9 zeros
        {6'b000000, 1'b0, 1'b1, 2'b01, 16'hFFFF, 16'hF510}, // R10 low lane only
        {6'b000000, 1'b0, 1'b1, 2'b11, 16'h8000, 16'h7510}, // R9 single bit
        {6'b000000, 1'b0, 1'b1, 2'b10, 16'hFFFF, 16'h0410}, // R10 R2 R3
        {6'b100000, 1'b0, 1'b1, 2'b11, 16'h8000, 16'h8410}, // R11
        {6'b000000, 1'b0, 1'b0, 2'b00, 16'h0000, 16'h8410}, // R12
        {6'b000001, 1'b1, 1'b1, 2'b11, 16'h0100, 16'h8510}, // R11 DPR
        {6'b000000, 1'b0, 1'b1, 2'b11, 16'hFFFF, 16'h0410}, // R9 all
        {6'b111011, 1'b1, 1'b0, 2'b00, 16'h0000, 16'hF510}  // R4..R8 together
    };

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
        end
    endtask

    task automatic idle();
        {ev_par_det, ev_serr, ev_mabort, ev_special, ev_tabort, ev_mst_par} = '0;
        perr_resp_en = 0; wr_en = 0; wr_be = 2'b00; wr_data = 16'h0000;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #5;
        check("R1 reset", 16'h0410);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 16'h0410);

        for (int i = 0; i < NVEC; i++) begin
            {ev_par_det, ev_serr, ev_mabort, ev_special, ev_tabort, ev_mst_par} = VEC[i][41:36];
            perr_resp_en = VEC[i][35];
            wr_en        = VEC[i][34];
            wr_be        = VEC[i][33:32];
            wr_data      = VEC[i][31:16];
            @(negedge clk);
            check($sformatf("vector %0d", i), VEC[i][15:0]);
        end
        idle();

        // R12: hold for several cycles
        repeat (5) @(negedge clk);
        check("R12 hold", 16'hF510);

        // R2 R3: write ones into hardwired bits only
        wr_en = 1; wr_be = 2'b11; wr_data = 16'h0EFF;
        @(negedge clk);
        idle();
        check("R2 R3 hardwired write", 16'hF510);

        // R10: lane 1 disabled, clear request on bit 8 ignored
        wr_en = 1; wr_be = 2'b01; wr_data = 16'h0100;
        @(negedge clk);
        idle();
        check("R10 disabled lane", 16'hF510);

        // R1: reset while flags are set
        rst_n = 1'b0;
        #3;
        check("R1 mid-run reset", 16'h0410);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after mid-run reset", 16'h0410);

        finish_run();
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

endmodule